// File: doc/BRIEF.md
# Multi-Mode Programmable Pin Controller

This block governs four general-purpose pins. Each pin is set by its own 2-bit field to one of four modes. In plain input mode, software reads the pin through a level register. In wake input mode, a falling edge on the pin sets an oscillator-enable flag. In plain output mode, the pin drives a stored level bit. In serial buffer mode, each pin takes a fixed pass-through role on the SPI wires, and that role depends on the chip-select level.

Software reaches the block through a small synchronous register port with four addresses. Address 0 holds the mode fields. Address 1 holds the pin levels. Address 2 holds the pull-up bit. Address 3 holds the oscillator-enable flag. The pads appear as separate input value, output value, output enable and pull-up enable vectors. The serial data output of the normal serial logic enters the block and is muxed onto the outgoing data line. The reset is asynchronous and active-low, and it is released through a two-flop synchronizer.

Top module: `mmio_pin_ctrl`

## Requirements
- R1: After reset, all four mode fields read 00, the stored level bits, the pull-up bit and the oscillator flag (address 3, bit 0) read 0, and no pad is driven or pulled up.
- R2: Address 0 holds the mode field of pin n (n = 1..4) in bits [2n-1:2n-2] and reads back as written. Mode encodings: 00 input, 01 wake input, 10 output, 11 serial buffer.
- R3: In mode 00 the pad is not driven. Bit n-1 at address 1 returns the pad input as it stood two clock edges earlier.
- R4: In mode 01 the pad is not driven. A high-to-low change on the pad sets the oscillator flag on the third rising clock edge after the change. A rising edge, or a falling edge on a pin in any other mode, leaves the flag unchanged.
- R5: Once set, the oscillator flag holds until a write to address 3 loads it from wdata bit 0. When a wake edge and such a write land on the same edge, the flag ends up set.
- R6: In mode 10 the pad is driven with its stored level bit (address 1, bit n-1), and the level read returns that stored bit, whatever the pad input is.
- R7: With pin 1 in mode 11, pad 1 is not driven. While CS (active low) is high, the outgoing serial data line carries the raw pad 1 input. Pull-up enable 1 equals the pull-up bit (address 2, bit 0).
- R8: With pin 2 in mode 11, pad 2 is driven with DIN while CS is high, and with its stored level bit while CS is low.
- R9: With pin 3 in mode 11, pad 3 is driven with SCLK while CS is high, and with its stored level bit while CS is low.
- R10: With pin 4 in mode 11, pad 4 is always driven with the inverse of CS.
- R11: When pin 1 is not in mode 11, or CS is low, the outgoing serial data line equals the serial-logic data input.
- R12: The level read returns stored bits for driven pins and synchronized pad inputs for undriven pins, mixed per pin. Undriven pads output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 mode, 1 level, 2 pull-up, 3 oscillator flag) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address |
| pad_in_i | input | 4 | Pad input levels, pin 1 in bit 0 |
| pad_out_o | output | 4 | Pad output levels |
| pad_oe_o | output | 4 | Pad output enables |
| pad_pu_o | output | 4 | Pad pull-up enables |
| spi_csn_i | input | 1 | Serial chip select, active low |
| spi_sclk_i | input | 1 | Serial clock |
| spi_din_i | input | 1 | Serial data into the device |
| spi_dout_core_i | input | 1 | Serial data from the normal serial logic |
| spi_dout_o | output | 1 | Serial data out of the device |
| osc_en_o | output | 1 | Oscillator-enable flag |

## Verification
The assertions assume that the register port is driven only while reset is released, and that the pad and SPI inputs are stable around the clock edge. The pass-through paths are combinational and the wake path only holds for inputs that change between edges. The bench therefore changes every input one nanosecond after a falling clock edge, and it keeps register traffic off until the reset synchronizer has let go. The wake-versus-clear collision is produced by timing a write so that it lands on the same edge as the detected fall.

// File: rtl/mmio_pin_pkg.sv
`timescale 1ns/1ps
package mmio_pin_pkg;

  localparam int PIN_CNT     = 4;
  localparam int MODE_W      = 2;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 2;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_IN   = 2'b00,
    PM_WAKE = 2'b01,
    PM_OUT  = 2'b10,
    PM_BUF  = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    ROLE_DOUT = 2'd0,
    ROLE_DIN  = 2'd1,
    ROLE_SCLK = 2'd2,
    ROLE_CSN  = 2'd3
  } pin_role_e;

  localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
  localparam logic [ADDR_W-1:0] A_LEVEL = 2'd1;
  localparam logic [ADDR_W-1:0] A_PULL  = 2'd2;
  localparam logic [ADDR_W-1:0] A_OSC   = 2'd3;

  function automatic pin_role_e role_of(input int unsigned idx);
    logic [1:0] r;
    r = idx[1:0];
    return pin_role_e'(r);
  endfunction

endpackage

// File: rtl/mmio_pin_rst_sync.sv
`timescale 1ns/1ps
module mmio_pin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/mmio_pin_in_sync.sv
`timescale 1ns/1ps
module mmio_pin_in_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] fall_o
);

  // stage[STAGES-1] is the synchronized level; stage[STAGES] is its delayed copy
  logic [STAGES:0][WIDTH-1:0] stage_q;
  logic [STAGES:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = pad_in_i;
    for (int k = 1; k <= STAGES; k++) begin
      stage_d[k] = stage_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign fall_o = stage_q[STAGES] & ~stage_q[STAGES-1];

endmodule

// File: rtl/mmio_pin_regs.sv
`timescale 1ns/1ps
module mmio_pin_regs
  import mmio_pin_pkg::*;
#(
  parameter int PINS = PIN_CNT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [REG_W-1:0]       wdata_i,
  input  logic [PINS-1:0]        sync_lvl_i,
  input  logic [PINS-1:0]        fall_i,
  input  logic [PINS-1:0]        out_type_i,
  output logic [PINS*MODE_W-1:0] mode_o,
  output logic [PINS-1:0]        lvl_o,
  output logic                   pu_o,
  output logic                   osc_o,
  output logic [REG_W-1:0]       rdata_o
);

  localparam int MODE_BITS = PINS * MODE_W;
  localparam int PAD_W     = REG_W - PINS;

  logic [MODE_BITS-1:0] mode_q, mode_d;
  logic [PINS-1:0]      lvl_q, lvl_d;
  logic                 pu_q, pu_d;
  logic                 osc_q, osc_d;
  logic                 mode_en, lvl_en, pu_en, osc_wr;
  logic                 wake_hit;
  logic [PINS-1:0]      lvl_view;

  // write decode
  always_comb begin
    mode_en = wr_i && (addr_i == A_MODE);
    lvl_en  = wr_i && (addr_i == A_LEVEL);
    pu_en   = wr_i && (addr_i == A_PULL);
    osc_wr  = wr_i && (addr_i == A_OSC);
  end

  // wake detection: only pins in wake mode contribute
  always_comb begin
    wake_hit = 1'b0;
    for (int i = 0; i < PINS; i++) begin
      if ((pin_mode_e'(mode_q[i*MODE_W +: MODE_W]) == PM_WAKE) && fall_i[i]) begin
        wake_hit = 1'b1;
      end
    end
  end

  // next state
  always_comb begin
    mode_d = mode_q;
    lvl_d  = lvl_q;
    pu_d   = pu_q;
    osc_d  = osc_q;
    if (mode_en) mode_d = wdata_i[MODE_BITS-1:0];
    if (lvl_en)  lvl_d  = wdata_i[PINS-1:0];
    if (pu_en)   pu_d   = wdata_i[0];
    if (wake_hit) begin
      osc_d = 1'b1;
    end else if (osc_wr) begin
      osc_d = wdata_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lvl_q  <= '0;
      pu_q   <= 1'b0;
      osc_q  <= 1'b0;
    end else begin
      if (mode_en)            mode_q <= mode_d;
      if (lvl_en)             lvl_q  <= lvl_d;
      if (pu_en)              pu_q   <= pu_d;
      if (wake_hit || osc_wr) osc_q  <= osc_d;
    end
  end

  // level view: stored bit for driven pins, synchronized input otherwise
  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      lvl_view[i] = out_type_i[i] ? lvl_q[i] : sync_lvl_i[i];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = mode_q;
      A_LEVEL: rdata_o = {{PAD_W{1'b0}}, lvl_view};
      A_PULL:  rdata_o = {{(REG_W-1){1'b0}}, pu_q};
      default: rdata_o = {{(REG_W-1){1'b0}}, osc_q};
    endcase
  end

  assign mode_o = mode_q;
  assign lvl_o  = lvl_q;
  assign pu_o   = pu_q;
  assign osc_o  = osc_q;

endmodule

// File: rtl/mmio_pin_cell.sv
`timescale 1ns/1ps
module mmio_pin_cell
  import mmio_pin_pkg::*;
#(
  parameter pin_role_e ROLE = ROLE_DOUT
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              lvl_i,
  input  logic              pu_i,
  input  logic              pad_in_i,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              pad_out_o,
  output logic              pad_oe_o,
  output logic              pad_pu_o,
  output logic              dout_vld_o,
  output logic              dout_o
);

  pin_mode_e mode;
  assign mode = pin_mode_e'(mode_i);

  always_comb begin
    pad_out_o  = 1'b0;
    pad_oe_o   = 1'b0;
    pad_pu_o   = 1'b0;
    dout_vld_o = 1'b0;
    dout_o     = 1'b0;
    unique case (mode)
      PM_OUT: begin
        pad_oe_o  = 1'b1;
        pad_out_o = lvl_i;
      end
      PM_BUF: begin
        unique case (ROLE)
          ROLE_DOUT: begin
            pad_pu_o   = pu_i;
            dout_vld_o = csn_i;
            dout_o     = pad_in_i & csn_i;
          end
          ROLE_DIN: begin
            pad_oe_o  = 1'b1;
            pad_out_o = csn_i ? din_i : lvl_i;
          end
          ROLE_SCLK: begin
            pad_oe_o  = 1'b1;
            pad_out_o = csn_i ? sclk_i : lvl_i;
          end
          default: begin
            pad_oe_o  = 1'b1;
            pad_out_o = ~csn_i;
          end
        endcase
      end
      default: begin
        pad_out_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/mmio_pin_ctrl.sv
`timescale 1ns/1ps
module mmio_pin_ctrl
  import mmio_pin_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [PIN_CNT-1:0] pad_in_i,
  output logic [PIN_CNT-1:0] pad_out_o,
  output logic [PIN_CNT-1:0] pad_oe_o,
  output logic [PIN_CNT-1:0] pad_pu_o,
  input  logic              spi_csn_i,
  input  logic              spi_sclk_i,
  input  logic              spi_din_i,
  input  logic              spi_dout_core_i,
  output logic              spi_dout_o,
  output logic              osc_en_o
);

  localparam int MODE_BITS = PIN_CNT * MODE_W;

  logic                 rst_n_sync;
  logic [MODE_BITS-1:0] mode_q;
  logic [PIN_CNT-1:0]   lvl_q;
  logic                 pu_q;
  logic [PIN_CNT-1:0]   sync_lvl;
  logic [PIN_CNT-1:0]   wake_fall;
  logic [PIN_CNT-1:0]   dout_vld;
  logic [PIN_CNT-1:0]   dout_bit;

  mmio_pin_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_sync)
  );

  mmio_pin_in_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .pad_in_i (pad_in_i),
    .sync_o   (sync_lvl),
    .fall_o   (wake_fall)
  );

  mmio_pin_regs #(.PINS(PIN_CNT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .sync_lvl_i (sync_lvl),
    .fall_i     (wake_fall),
    .out_type_i (pad_oe_o),
    .mode_o     (mode_q),
    .lvl_o      (lvl_q),
    .pu_o       (pu_q),
    .osc_o      (osc_en_o),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_cell
    mmio_pin_cell #(.ROLE(role_of(g))) u_cell (
      .mode_i     (mode_q[g*MODE_W +: MODE_W]),
      .lvl_i      (lvl_q[g]),
      .pu_i       (pu_q),
      .pad_in_i   (pad_in_i[g]),
      .csn_i      (spi_csn_i),
      .sclk_i     (spi_sclk_i),
      .din_i      (spi_din_i),
      .pad_out_o  (pad_out_o[g]),
      .pad_oe_o   (pad_oe_o[g]),
      .pad_pu_o   (pad_pu_o[g]),
      .dout_vld_o (dout_vld[g]),
      .dout_o     (dout_bit[g])
    );
  end

  assign spi_dout_o = (|dout_vld) ? (|(dout_bit & dout_vld)) : spi_dout_core_i;

endmodule

// File: rtl/mmio_pin_ctrl_chk.sv
`timescale 1ns/1ps
module mmio_pin_ctrl_chk (
  input logic       clk,
  input logic       arst_n,
  input logic [7:0] mode_q,
  input logic       reg_wr_i,
  input logic [1:0] reg_addr_i,
  input logic [3:0] pad_oe_o,
  input logic [3:0] pad_out_o,
  input logic       spi_csn_i,
  input logic       spi_dout_core_i,
  input logic       spi_dout_o,
  input logic       osc_en_o
);

  logic osc_wr;
  logic any_wake;
  assign osc_wr   = reg_wr_i && (reg_addr_i == 2'd3);
  assign any_wake = (mode_q[1:0] == 2'b01) || (mode_q[3:2] == 2'b01) ||
                    (mode_q[5:4] == 2'b01) || (mode_q[7:6] == 2'b01);

  // R3
  pad1_undriven_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_q[1:0] != 2'b10) |-> !pad_oe_o[0]);

  // R5
  osc_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (osc_en_o && !osc_wr) |=> osc_en_o);

  // R4
  osc_rise_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(osc_en_o) |-> ($past(osc_wr) || $past(any_wake)));

  // R10
  pin4_inv_cs_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_q[7:6] == 2'b11) |-> (pad_oe_o[3] && (pad_out_o[3] == !spi_csn_i)));

  // R11
  dout_bypass_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ((mode_q[1:0] != 2'b11) || !spi_csn_i) |-> (spi_dout_o == spi_dout_core_i));

  // R6
  pin3_out_enable_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_q[5:4] == 2'b10) |-> pad_oe_o[2]);

endmodule

bind mmio_pin_ctrl mmio_pin_ctrl_chk u_chk (
  .clk             (clk),
  .arst_n          (arst_n),
  .mode_q          (mode_q),
  .reg_wr_i        (reg_wr_i),
  .reg_addr_i      (reg_addr_i),
  .pad_oe_o        (pad_oe_o),
  .pad_out_o       (pad_out_o),
  .spi_csn_i       (spi_csn_i),
  .spi_dout_core_i (spi_dout_core_i),
  .spi_dout_o      (spi_dout_o),
  .osc_en_o        (osc_en_o)
);

// File: tb/mmio_pin_ctrl_tb_top.sv
`timescale 1ns/1ps
module mmio_pin_ctrl_tb_top;

  logic       clk;
  logic       arst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [3:0] pad_in;
  logic [3:0] pad_out, pad_oe, pad_pu;
  logic       csn, sclk, din, core_dout, dout, osc;

  mmio_pin_ctrl dut_i (
    .clk (clk), .arst_n (arst_n),
    .reg_wr_i (reg_wr), .reg_addr_i (reg_addr), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .pad_in_i (pad_in), .pad_out_o (pad_out), .pad_oe_o (pad_oe), .pad_pu_o (pad_pu),
    .spi_csn_i (csn), .spi_sclk_i (sclk), .spi_din_i (din),
    .spi_dout_core_i (core_dout), .spi_dout_o (dout), .osc_en_o (osc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_vec  = 0;
  int    n_fail = 0;
  bit    cmp_en = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit [7:0] m_mode;
  bit [3:0] m_lvl;
  bit       m_pu, m_osc;
  bit [3:0] hist[$];
  int       rel_cnt;

  function automatic bit [1:0] fld(int p);
    return m_mode[2*p +: 2];
  endfunction

  function automatic bit drives(int p);
    if (fld(p) == 2'b10) return 1;
    if (fld(p) == 2'b11 && p != 0) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!arst_n || rel_cnt < 2) begin
      if (!arst_n) rel_cnt = 0; else rel_cnt++;
      m_mode = 0; m_lvl = 0; m_pu = 0; m_osc = 0;
      hist = '{4'h0, 4'h0, 4'h0};
    end else begin
      bit [3:0] fell;
      bit hit;
      fell = hist[0] & ~hist[1];
      hit = 0;
      for (int p = 0; p < 4; p++) if (fld(p) == 2'b01 && fell[p]) hit = 1;
      if (hit) m_osc = 1;
      else if (reg_wr && reg_addr == 2'd3) m_osc = reg_wdata[0];
      if (reg_wr && reg_addr == 2'd0) m_mode = reg_wdata;
      if (reg_wr && reg_addr == 2'd1) m_lvl = reg_wdata[3:0];
      if (reg_wr && reg_addr == 2'd2) m_pu = reg_wdata[0];
      hist.push_back(pad_in);
      void'(hist.pop_front());
    end
  end

  task automatic chk(string what, logic [7:0] got, logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      bit [3:0] e_out, e_oe, e_pu, view;
      bit       e_dout;
      bit [7:0] e_rd;
      for (int p = 0; p < 4; p++) begin
        e_oe[p] = drives(p);
        case (fld(p))
          2'b10:   e_out[p] = m_lvl[p];
          2'b11:   case (p)
                     1: e_out[p] = csn ? din : m_lvl[1];
                     2: e_out[p] = csn ? sclk : m_lvl[2];
                     3: e_out[p] = ~csn;
                     default: e_out[p] = 0;
                   endcase
          default: e_out[p] = 0;
        endcase
        view[p] = e_oe[p] ? m_lvl[p] : hist[1][p];
      end
      e_pu   = {3'b000, m_pu && fld(0) == 2'b11};
      e_dout = (fld(0) == 2'b11 && csn) ? pad_in[0] : core_dout;
      case (reg_addr)
        2'd0: e_rd = m_mode;
        2'd1: e_rd = {4'h0, view};
        2'd2: e_rd = {7'h0, m_pu};
        default: e_rd = {7'h0, m_osc};
      endcase
      chk("pad_out", {4'h0, pad_out}, {4'h0, e_out});
      chk("pad_oe",  {4'h0, pad_oe},  {4'h0, e_oe});
      chk("pad_pu",  {4'h0, pad_pu},  {4'h0, e_pu});
      chk("dout",    {7'h0, dout},    {7'h0, e_dout});
      chk("osc",     {7'h0, osc},     {7'h0, m_osc});
      chk("rdata",   reg_rdata,       e_rd);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(bit [1:0] a, bit [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(bit [1:0] a, int n = 1);
    reg_addr = a;
    tick(n);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    arst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    pad_in = 4'hF; csn = 1; sclk = 0; din = 0; core_dout = 0;
    tick(4);
    arst_n = 1;
    tick(1);
    cmp_en = 1;
    // R1: reset state at every address
    cur_req = "R1";
    for (int a = 0; a < 4; a++) rd(a[1:0], 2);

    // R2: field layout
    cur_req = "R2";
    wr(2'd0, 8'hE4); rd(2'd0, 2);
    wr(2'd0, 8'h1B); rd(2'd0, 2);
    wr(2'd0, 8'h00); rd(2'd0, 1);

    // R3: plain input readback
    cur_req = "R3";
    reg_addr = 2'd1;
    foreach (hist[i]) ;
    for (int v = 0; v < 16; v++) begin
      pad_in = v[3:0] ^ 4'h5;
      tick(1);
    end
    tick(3);

    // R4: wake on falling edge only
    cur_req = "R4";
    pad_in = 4'hF; tick(4);
    wr(2'd0, 8'h04);          // pin 2 wake, others input
    wr(2'd3, 8'h00);
    reg_addr = 2'd3;
    pad_in = 4'hE; tick(5);   // fall on pin 1 (not wake) -> no set
    pad_in = 4'hF; tick(5);   // rise only
    pad_in = 4'hD; tick(5);   // fall on pin 2 -> set
    pad_in = 4'hF; tick(3);

    // R5: hold and clear, collision
    cur_req = "R5";
    wr(2'd1, 8'h0F); wr(2'd2, 8'h01); rd(2'd3, 2);
    wr(2'd3, 8'h00); rd(2'd3, 2);
    wr(2'd3, 8'h01); rd(2'd3, 2);
    wr(2'd3, 8'h00); tick(2);
    pad_in = 4'hD; tick(2);
    wr(2'd3, 8'h00);          // lands with the detected fall
    rd(2'd3, 3);
    pad_in = 4'hF; tick(3);
    wr(2'd3, 8'h00); rd(2'd3, 2);

    // R6: outputs ignore the pad input
    cur_req = "R6";
    wr(2'd0, 8'hAA);
    reg_addr = 2'd1;
    wr(2'd1, 8'h0A); reg_addr = 2'd1;
    for (int v = 0; v < 4; v++) begin pad_in = v[3:0] * 4'h5; tick(2); end
    wr(2'd1, 8'h05); reg_addr = 2'd1;
    for (int v = 0; v < 4; v++) begin pad_in = ~(v[3:0] * 4'h3); tick(2); end

    // R7..R10: buffer mode, all combinations of the pass-through inputs
    wr(2'd0, 8'hFF); wr(2'd1, 8'h0A); wr(2'd2, 8'h01);
    reg_addr = 2'd1;
    for (int v = 0; v < 32; v++) begin
      case (v % 4)
        0: cur_req = "R7";
        1: cur_req = "R8";
        2: cur_req = "R9";
        default: cur_req = "R10";
      endcase
      csn = v[0]; sclk = v[1]; din = v[2]; core_dout = v[3]; pad_in[0] = v[4];
      tick(1);
    end
    wr(2'd2, 8'h00); tick(2);

    // R11: bypass when pin 1 is not in buffer mode
    cur_req = "R11";
    for (int m = 0; m < 3; m++) begin
      wr(2'd0, {6'h3F, m[1:0]});
      for (int v = 0; v < 8; v++) begin
        csn = v[0]; core_dout = v[1]; pad_in[0] = v[2];
        tick(1);
      end
    end

    // R12: mixed readback
    cur_req = "R12";
    wr(2'd1, 8'h09);
    foreach (m_lvl[i]) ;
    wr(2'd0, 8'h9C); reg_addr = 2'd1;
    for (int v = 0; v < 16; v++) begin pad_in = v[3:0]; csn = v[0]; tick(1); end
    wr(2'd0, 8'h63); reg_addr = 2'd1;
    for (int v = 0; v < 16; v++) begin pad_in = ~v[3:0]; csn = v[1]; tick(1); end
    tick(3);

    // R1: reset in the middle of activity
    cur_req = "R1";
    cmp_en = 0;
    arst_n = 0; tick(3);
    arst_n = 1; tick(1);
    cmp_en = 1;
    for (int a = 0; a < 4; a++) rd(a[1:0], 2);

    done = 1;
    summary();
    $finish;
  end

endmodule